// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte control register on a simple I/O port bus. It answers at a single port address and accepts only byte-sized accesses. A read returns whatever byte was last written. A write stores the byte. If the write moves the trigger bit from 0 to 1, the block sends a one-cycle request to the system reset controller. Alongside that request it reports whether the reset is soft or hard.

Soft and hard resets travel on the same request line. The type bit is only a side output, and it keeps its value until the next request is issued. Accesses of the wrong size at the block's address are refused with an error pulse and change nothing. Accesses to any other address are ignored without an error. The read data, the error flag, the request and the type output are all registered, so each answers one clock after the access that caused it.

Top module: `rstctl_port`

## Requirements
- R1: Only accesses whose address equals the port address (default 0xCF9) are decoded. Accesses to any other address leave the stored byte unchanged, give no error, give no reset request, and return read data 0x00.
- R2: The size field encodes 0 as a byte access. Sizes 1, 2 and 3 at the port address are refused. A refusal raises `bus_err` for one cycle, one clock after the access, returns read data 0x00 and does not change the stored byte.
- R3: An accepted read returns the full stored byte on `bus_rdata` one clock after the read strobe. In every other cycle `bus_rdata` is 0x00.
- R4: An accepted write whose bit 2 is 1, while the stored bit 2 is 0, raises `rst_req` for exactly one cycle, one clock after the write.
- R5: When `rst_req` rises, `rst_hard` equals bit 1 of the same write (0 means soft, 1 means hard). `rst_hard` holds that value until the next request.
- R6: An accepted write with bit 2 set, while the stored bit 2 is already 1, produces no request.
- R7: After reset the stored byte is 0x00 and `bus_rdata`, `bus_err`, `rst_req` and `rst_hard` are all 0.
- R8: A soft-type trigger and a hard-type trigger both raise the same `rst_req` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Port address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data, 0x00 when no accepted read |
| bus_err | output | 1 | Registered one-cycle error for a refused access |
| rst_req | output | 1 | One-cycle reset request to the reset controller |
| rst_hard | output | 1 | Reset type of the last request: 1 hard, 0 soft |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. That case is checked as an input rule; if it happens anyway, the write wins. Every access in the stimulus, both directed and random, carries at most one strobe. The random phase chooses addresses from the port address and one nearby address, and it cycles through all four size codes. This lets trigger edges, repeated triggers and refused accesses fall in arbitrary order.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        size,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              refuse
);
  import rstctl_pkg::*;
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

  logic hit, is_byte;

  always_comb begin
    hit     = (addr == MATCH);
    is_byte = (size == ACC_BYTE);
    wr_ok   = hit && wr && is_byte;
    rd_ok   = hit && rd && !wr && is_byte;
    refuse  = hit && (rd || wr) && !is_byte;
  end
endmodule

// File: rtl/rstctl_store.sv
module rstctl_store #(
  parameter int DATA_W   = 8,
  parameter int GO_BIT   = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              req,
  output logic              hard
);
  logic fire;

  always_comb fire = wr_ok && wdata[GO_BIT] && !value[GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      req   <= 1'b0;
      hard  <= 1'b0;
    end else begin
      req <= fire;
      if (wr_ok) value <= wdata;
      if (fire)  hard  <= wdata[TYPE_BIT];
    end
  end
endmodule

// File: rtl/rstctl_port.sv
module rstctl_port #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'hCF9,
  parameter int          GO_BIT    = 2,
  parameter int          TYPE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              rst_req,
  output logic              rst_hard
);
  logic              wr_ok, rd_ok, refuse;
  logic [DATA_W-1:0] value;

  rstctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .size(bus_size),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .refuse(refuse)
  );

  rstctl_store #(.DATA_W(DATA_W), .GO_BIT(GO_BIT), .TYPE_BIT(TYPE_BIT)) u_store (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wdata(bus_wdata),
    .value(value), .req(rst_req), .hard(rst_hard)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_ok ? value : '0;
      bus_err   <= refuse;
    end
  end
endmodule

// File: rtl/rstctl_port_checks.sv
module rstctl_port_checks #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'hCF9,
  parameter int          GO_BIT    = 2,
  parameter int          TYPE_BIT  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              rst_req,
  input logic              rst_hard
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

  a_in_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R4: request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R4: request only follows an accepted byte write with the trigger bit set
  a_r4_req_cause: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(bus_wr && bus_addr == MATCH && bus_size == 2'd0 && bus_wdata[GO_BIT]));

  // R5: type output matches the triggering write and is held otherwise
  a_r5_type_on_req: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> rst_hard == $past(bus_wdata[TYPE_BIT]));
  a_r5_type_hold: assert property (@(posedge clk) disable iff (rst)
    !rst_req |-> $stable(rst_hard));

  // R2: error only after a wrong-size access at the port
  a_r2_err_cause: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past((bus_rd || bus_wr) && bus_addr == MATCH && bus_size != 2'd0));

  // R1: foreign addresses give neither error nor request
  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr != MATCH) |=> (!bus_err && !rst_req));

  // R3: read data is zero when no read was presented
  a_r3_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind rstctl_port rstctl_port_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
  .GO_BIT(GO_BIT), .TYPE_BIT(TYPE_BIT)
) u_checks (.*);

// File: tb/rstctl_port_test.sv
`timescale 1ns/1ps
module rstctl_port_test;
  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_err, rst_req, rst_hard;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_reg = '0;
  logic       m_hard = 1'b0;

  always #10 clk = ~clk;

  rstctl_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rst_req(rst_req), .rst_hard(rst_hard)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive one access, advance the model, compare next negedge.
  task automatic step(input logic rd, input logic wr, input logic [15:0] addr,
                      input logic [1:0] sz, input logic [7:0] wd);
    logic hit, e_err, e_req, e_hard;
    logic [7:0] e_rdata;
    string req_tag;
    hit = (addr == PORT);
    bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_size = sz; bus_wdata = wd;
    e_err   = hit && (rd || wr) && (sz != 2'd0);
    e_rdata = (hit && rd && !wr && sz == 2'd0) ? m_reg : 8'h00;
    e_req   = 1'b0;
    req_tag = "R4";
    if (hit && wr && sz == 2'd0) begin
      if (wd[2] && m_reg[2]) req_tag = "R6";
      if (wd[2] && !m_reg[2]) begin
        e_req  = 1'b1;
        m_hard = wd[1];
      end
      m_reg = wd;
    end
    e_hard = m_hard;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check(hit ? "R3" : "R1", bus_rdata, e_rdata);
    check(hit ? "R2" : "R1", {7'b0, bus_err}, {7'b0, e_err});
    check(req_tag, {7'b0, rst_req}, {7'b0, e_req});
    if (e_req) check("R8", {7'b0, rst_req}, 8'h01);
    check("R5", {7'b0, rst_hard}, {7'b0, e_hard});
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset values
    check("R7", bus_rdata, 8'h00);
    check("R7", {7'b0, bus_err}, 8'h00);
    check("R7", {7'b0, rst_req}, 8'h00);
    check("R7", {7'b0, rst_hard}, 8'h00);
    step(1, 0, PORT, 2'd0, 8'h00);   // R7: stored byte reads 0x00
    // R3: store and read back without trigger
    step(0, 1, PORT, 2'd0, 8'h5A);
    step(1, 0, PORT, 2'd0, 8'h00);
    // R4 R5 R8: hard trigger
    step(0, 1, PORT, 2'd0, 8'h06);
    // R6: repeat with bit already set
    step(0, 1, PORT, 2'd0, 8'h06);
    step(0, 1, PORT, 2'd0, 8'hFE);
    step(0, 1, PORT, 2'd0, 8'h02);
    // R8: soft trigger
    step(0, 1, PORT, 2'd0, 8'h04);
    step(1, 0, PORT, 2'd0, 8'h00);
    // R2: refused sizes
    step(0, 1, PORT, 2'd1, 8'h00);
    step(1, 0, PORT, 2'd2, 8'h00);
    step(1, 0, PORT, 2'd0, 8'h00);
    step(0, 1, PORT, 2'd0, 8'h00);
    step(0, 1, PORT, 2'd3, 8'h06);   // R2: no trigger from refused write
    step(1, 0, PORT, 2'd0, 8'h00);
    // R1: foreign address
    step(0, 1, PORT + 16'd1, 2'd0, 8'h06);
    step(1, 0, PORT - 16'd1, 2'd0, 8'h00);
    step(1, 0, PORT, 2'd0, 8'h00);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      step(k[0], !k[0] && k[1], (k[2] && k[1]) ? PORT + 16'd4 : PORT,
           ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0,
           8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule